// File: doc/BRIEF.md
# Byte/Word Flash Data Bus Adapter

This block sits between a 16-bit internal array word port and the external data pins of a parallel NOR-style flash model. A mode input picks word or byte configuration. Active-low chip enable, output enable and write enable decide when the block drives the pins and when it accepts write data.

Real tri-state nets are avoided. Each data pin has its own drive-enable output, and the outputs are registered, so a change at the pins appears one clock after the edge that samples it.

In byte configuration only pins 7..0 carry data. Pins 14..8 are never driven. Pin 15 stops being data and becomes the address bit below bit 0, which picks the byte within the array word. On reads that bit chooses the byte placed on pins 7..0. On writes it chooses the byte-lane strobe.

Top module: `flash_bus_adapter`

## Requirements
- R1: After reset all outputs are zero: no pin driven, no write strobe, lane mask 0, data 0, captured address bit 0.
- R2: In word mode (mode input 1), a read cycle (ce_n=0, oe_n=0, we_n=1) makes dq_oe equal 16'hFFFF and dq_out equal arr_rdata one clock later.
- R3: In byte mode (mode input 0), a read cycle makes dq_oe equal 16'h00FF one clock later, so pins 15..8 are never driven. dq_out[15:8] is 0.
- R4: In byte mode, a read returns arr_rdata[7:0] on dq_out[7:0] when dq_in[15] is 0, and arr_rdata[15:8] when it is 1.
- R5: With ce_n=1, dq_oe is 0 and wr_stb is 0 one clock later.
- R6: With oe_n=1, or with oe_n and we_n both 0, dq_oe is 0 one clock later. Both low is the contention guard.
- R7: In word mode, a write cycle (ce_n=0, we_n=0, oe_n=1) pulses wr_stb one clock later, with wr_lane=2'b11 and wr_data=dq_in.
- R8: In byte mode, a write cycle pulses wr_stb with wr_lane=2'b01 when dq_in[15] is 0 and 2'b10 when it is 1. wr_data carries dq_in[7:0] in both bytes.
- R9: wr_stb is 0 one clock after any cycle that is not a write cycle, including oe_n=we_n=0.
- R10: addr_lsb shows dq_in[15] one clock later in byte mode, and shows 0 in word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| word_mode | input | 1 | 1 = word configuration, 0 = byte configuration |
| dq_in | input | 16 | Value seen on the data pins |
| arr_rdata | input | 16 | Array word for the current address |
| dq_out | output | 16 | Value to drive on the data pins |
| dq_oe | output | 16 | Per-pin drive enable |
| wr_stb | output | 1 | Write strobe toward the array |
| wr_lane | output | 2 | Byte lanes written (bit 0 low byte, bit 1 high byte) |
| wr_data | output | 16 | Write data toward the array |
| addr_lsb | output | 1 | Captured sub-word address bit |

## Verification
If the cycle-type decode is wrong, the pins are driven during a write or a disabled cycle, or the write strobe fires on a read. Either shows at dq_oe or wr_stb on the very next clock. If the byte-select state is wrong, the wrong half of the array word appears on the low pins, or the wrong lane is strobed, also one clock after the stimulus. Random mixes of mode, enables and pin values are compared every cycle against a bench model, so any such fault is reported in the cycle it first appears.

// File: rtl/flash_bus_adapter.sv
module flash_bus_adapter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          word_mode,
  input  logic [DW-1:0] dq_in,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  output logic          wr_stb,
  output logic [1:0]    wr_lane,
  output logic [DW-1:0] wr_data,
  output logic          addr_lsb
);
  localparam int HW = DW / 2;

  logic rd_cyc, wr_cyc, sub;
  logic [HW-1:0] rd_byte;

  assign rd_cyc  = !ce_n && !oe_n && we_n;
  assign wr_cyc  = !ce_n && !we_n && oe_n;
  assign sub     = !word_mode && dq_in[DW-1];
  assign rd_byte = sub ? arr_rdata[DW-1:HW] : arr_rdata[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out   <= '0;
      dq_oe    <= '0;
      wr_stb   <= 1'b0;
      wr_lane  <= 2'b00;
      wr_data  <= '0;
      addr_lsb <= 1'b0;
    end else begin
      addr_lsb <= sub;
      wr_stb   <= wr_cyc;
      if (rd_cyc) begin
        dq_oe  <= word_mode ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
        dq_out <= word_mode ? arr_rdata : {{HW{1'b0}}, rd_byte};
      end else begin
        dq_oe  <= '0;
      end
      if (wr_cyc) begin
        wr_lane <= word_mode ? 2'b11 : (sub ? 2'b10 : 2'b01);
        wr_data <= word_mode ? dq_in : {2{dq_in[HW-1:0]}};
      end else begin
        wr_lane <= 2'b00;
      end
    end
  end
endmodule

module flash_bus_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        word_mode,
  input logic [15:0] dq_oe,
  input logic        wr_stb,
  input logic [1:0]  wr_lane
);
  a_r5_ce_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> (dq_oe == 16'h0 && !wr_stb));
  a_r6_contention_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(oe_n) && !$past(we_n)) |-> (dq_oe == 16'h0));
  a_r3_upper_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(word_mode) |-> (dq_oe[15:8] == 8'h0));
  a_r9_no_drive_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (dq_oe == 16'h0));
  a_r8_one_lane_in_byte_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !$past(word_mode)) |-> ($countones(wr_lane) == 1));
  a_r7_both_lanes_in_word_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(word_mode)) |-> (wr_lane == 2'b11));
endmodule

bind flash_bus_adapter flash_bus_adapter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .word_mode(word_mode), .dq_oe(dq_oe), .wr_stb(wr_stb), .wr_lane(wr_lane)
);

// File: tb/test_flash_bus_adapter.sv
`timescale 1ns/1ps
module test_flash_bus_adapter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, word_mode = 1'b1;
  logic [15:0] dq_in = '0, arr_rdata = '0;
  logic [15:0] dq_out, dq_oe, wr_data;
  logic wr_stb, addr_lsb;
  logic [1:0] wr_lane;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  flash_bus_adapter i_flash_bus_adapter (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .dq_in(dq_in), .arr_rdata(arr_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_stb(wr_stb), .wr_lane(wr_lane),
    .wr_data(wr_data), .addr_lsb(addr_lsb));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_oe(logic c, logic o, logic w, logic m);
    if (c || o || !w) return 16'h0;
    return m ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] exp_rd(logic m, logic [15:0] a, logic s);
    if (m) return a;
    return {8'h00, s ? a[15:8] : a[7:0]};
  endfunction

  function automatic logic [1:0] exp_lane(logic c, logic o, logic w, logic m, logic s);
    if (c || w || !o) return 2'b00;
    if (m) return 2'b11;
    return s ? 2'b10 : 2'b01;
  endfunction

  task automatic drive(input logic c, input logic o, input logic w, input logic m,
                       input logic [15:0] d, input logic [15:0] a);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; word_mode = m; dq_in = d; arr_rdata = a;
    @(posedge clk);
    #5;
  endtask

  task automatic check_all(input logic c, input logic o, input logic w, input logic m,
                           input logic [15:0] d, input logic [15:0] a);
    logic [15:0] eoe;
    logic [1:0] eln;
    eoe = exp_oe(c, o, w, m);
    eln = exp_lane(c, o, w, m, d[15]);
    chk(c ? "R5 dq_oe" : (m ? "R2/R6 dq_oe" : "R3/R6 dq_oe"), {16'h0, dq_oe}, {16'h0, eoe});
    if (eoe != 0) chk(m ? "R2 dq_out" : "R4 dq_out", {16'h0, dq_out}, {16'h0, exp_rd(m, a, d[15])});
    chk("R9 wr_stb", {31'h0, wr_stb}, {31'h0, eln != 0});
    chk(m ? "R7 wr_lane" : "R8 wr_lane", {30'h0, wr_lane}, {30'h0, eln});
    if (eln != 0) chk(m ? "R7 wr_data" : "R8 wr_data", {16'h0, wr_data},
                      {16'h0, m ? d : {d[7:0], d[7:0]}});
    chk("R10 addr_lsb", {31'h0, addr_lsb}, {31'h0, !m && d[15]});
  endtask

  task automatic step(input logic c, input logic o, input logic w, input logic m,
                      input logic [15:0] d, input logic [15:0] a);
    drive(c, o, w, m, d, a);
    check_all(c, o, w, m, d, a);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    #5;
    chk("R1 dq_oe", {16'h0, dq_oe}, 0);
    chk("R1 dq_out", {16'h0, dq_out}, 0);
    chk("R1 wr_stb", {31'h0, wr_stb}, 0);
    chk("R1 wr_lane", {30'h0, wr_lane}, 0);
    chk("R1 wr_data", {16'h0, wr_data}, 0);
    chk("R1 addr_lsb", {31'h0, addr_lsb}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 1, 1, 16'h0000, 16'hA55A);  // R2 word read
    step(0, 0, 1, 0, 16'h0000, 16'hC3E1);  // R4 low byte
    step(0, 0, 1, 0, 16'h8000, 16'hC3E1);  // R4 high byte, R10
    step(1, 0, 1, 1, 16'h0000, 16'hFFFF);  // R5
    step(0, 0, 0, 1, 16'h1234, 16'hFFFF);  // R6 contention, R9
    step(0, 1, 0, 1, 16'hBEEF, 16'h0000);  // R7 word write
    step(0, 1, 0, 0, 16'h7F3C, 16'h0000);  // R8 low lane
    step(0, 1, 0, 0, 16'h813C, 16'h0000);  // R8 high lane
    step(1, 1, 0, 0, 16'h813C, 16'h0000);  // R5 no write when deselected
    for (int i = 0; i < 600; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0] & r[1], r[2], r[3], 1'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule